// File: doc/BRIEF.md
# Three-Key Sequence Lock

This block is the decision core of a keypad door lock. It watches a stream of already-synchronized key events and releases the door only when three presses arrive in the order B, A, B. A press is one clock cycle with the valid flag high and exactly one of the two identity bits set. Cycles without a legal press leave the lock where it is.

The block is a Moore machine with six states in a 3-bit register. Both outputs are decoded from that register only. The first output is a one-cycle unlock strobe. The second is a 4-bit count of the keys taken so far in the current attempt, meant for a display decoder.

A wrong first or second key does not end the attempt. The lock moves to a separate path that keeps counting up to three and then drops back to idle. The display therefore looks the same whether the entry was right or wrong, until the third key has been taken. A wrong third key returns the lock to idle at once.

Top module: `seqlock_top`

## Requirements
- R1: While `rst` is high at a rising edge, the lock goes to idle. From the next cycle `unlock` is 0 and `keys_entered` is 0, and this also applies in the middle of an attempt.
- R2: The key code is {`key_vld`,`key_a`,`key_b`}. Code 110 is key A and code 101 is key B. Every other code, for example 111, 100, 011 or 001, counts as no key and changes nothing.
- R3: Starting from idle, the presses B, A, B make `keys_entered` read 1, 2 and then 3. `unlock` is high in the cycle where the count reads 3.
- R4: `unlock` stays high for exactly one cycle. In the next cycle the lock is idle again with a count of 0, whatever key is applied while the count reads 3.
- R5: A cycle with no key leaves `keys_entered` and `unlock` unchanged in every state except the unlocked state.
- R6: If the first key is A, the count still reads 1 and then 2 on later presses. The third press of any kind returns the lock to idle with a count of 0, and `unlock` stays low.
- R7: If the second key is B after a correct first B, the count reads 2. The next press of any kind returns the lock to idle, and `unlock` stays low.
- R8: If the third key is A after a correct B, A, the lock returns to idle with a count of 0 and no unlock.
- R9: The outputs change only in the cycle after a rising edge that consumed a key. A new input value never changes them within the same cycle.
- R10: A key held high for several cycles counts as one press per cycle.
- R11: `keys_entered` never exceeds 3, so its upper bits are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_vld | input | 1 | A key is present this cycle |
| key_a | input | 1 | Identity bit for key A |
| key_b | input | 1 | Identity bit for key B |
| unlock | output | 1 | One-cycle release strobe |
| keys_entered | output | 4 | Number of keys taken in the current attempt (0 to 3) |

## Verification
A key applied during a cycle is taken at the following rising edge. Its effect on `unlock` and `keys_entered` is due one register later, so it is visible just after that edge. The driver sets the inputs on the falling edge and queues the expected output pair. The monitor compares the pair 1 ns after the next rising edge.

The driver also samples the outputs 1 ns after it changes the inputs, before any edge has occurred. At that point they must still show the previous expectation, which is how the Moore behaviour of R9 is checked. The reset result is checked one edge after `rst` is sampled high.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

  localparam int ST_W = 3;

  // State codes are fixed; codes 110 and 111 are unused.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'b000,
    ST_OK1  = 3'b001,
    ST_OK2  = 3'b010,
    ST_OPEN = 3'b011,
    ST_BAD1 = 3'b100,
    ST_BAD2 = 3'b101
  } lock_st_e;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_A    = 2'd1,
    KEY_B    = 2'd2
  } key_e;

endpackage

// File: rtl/seqlock_keydec.sv
module seqlock_keydec
  import seqlock_pkg::*;
(
  input  logic key_vld,
  input  logic key_a,
  input  logic key_b,
  output key_e key
);

  always_comb begin
    unique case ({key_vld, key_a, key_b})
      3'b110:  key = KEY_A;
      3'b101:  key = KEY_B;
      default: key = KEY_NONE;
    endcase
  end

endmodule

// File: rtl/seqlock_next.sv
module seqlock_next
  import seqlock_pkg::*;
(
  input  lock_st_e cur,
  input  key_e     key,
  output lock_st_e nxt
);

  logic pressed;
  assign pressed = (key != KEY_NONE);

  always_comb begin
    nxt = ST_IDLE;
    case (cur)
      ST_IDLE: begin
        if (key == KEY_B)      nxt = ST_OK1;
        else if (key == KEY_A) nxt = ST_BAD1;
        else                   nxt = ST_IDLE;
      end
      ST_OK1: begin
        if (key == KEY_A)      nxt = ST_OK2;
        else if (key == KEY_B) nxt = ST_BAD2;
        else                   nxt = ST_OK1;
      end
      ST_OK2: begin
        if (key == KEY_B)      nxt = ST_OPEN;
        else if (key == KEY_A) nxt = ST_IDLE;
        else                   nxt = ST_OK2;
      end
      ST_OPEN: nxt = ST_IDLE;
      ST_BAD1: nxt = pressed ? ST_BAD2 : ST_BAD1;
      ST_BAD2: nxt = pressed ? ST_IDLE : ST_BAD2;
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seqlock_outdec.sv
module seqlock_outdec
  import seqlock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  lock_st_e         cur,
  output logic             unlock,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    unlock = 1'b0;
    count  = '0;
    case (cur)
      ST_OK1, ST_BAD1: count = CNT_W'(1);
      ST_OK2, ST_BAD2: count = CNT_W'(2);
      ST_OPEN: begin
        count  = CNT_W'(3);
        unlock = 1'b1;
      end
      default: begin
        count  = '0;
        unlock = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seqlock_top.sv
module seqlock_top
  import seqlock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_vld,
  input  logic             key_a,
  input  logic             key_b,
  output logic             unlock,
  output logic [CNT_W-1:0] keys_entered
);

  key_e     key;
  lock_st_e st_q;
  lock_st_e st_d;

  seqlock_keydec u_keydec (
    .key_vld (key_vld),
    .key_a   (key_a),
    .key_b   (key_b),
    .key     (key)
  );

  seqlock_next u_next (
    .cur (st_q),
    .key (key),
    .nxt (st_d)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  seqlock_outdec #(.CNT_W(CNT_W)) u_outdec (
    .cur    (st_q),
    .unlock (unlock),
    .count  (keys_entered)
  );

endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             key_vld,
  input logic             key_a,
  input logic             key_b,
  input logic             unlock,
  input logic [CNT_W-1:0] keys_entered
);

  logic legal_key;
  assign legal_key = key_vld && (key_a ^ key_b);

  // R1: reset clears both outputs one edge later
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (keys_entered == '0 && !unlock));

  // R4: the strobe lasts one cycle and is followed by idle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    unlock |=> (!unlock && keys_entered == '0));

  // R3: an unlock is always preceded by a B press
  a_r3_unlock_after_b: assert property (@(posedge clk) disable iff (rst)
    unlock |-> $past(key_vld && !key_a && key_b));

  // R5: a cycle without a legal key holds the count
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!unlock && !legal_key) |=> $stable(keys_entered));

  // R11: the count stays within 0 to 3
  a_r11_count_range: assert property (@(posedge clk) disable iff (rst)
    keys_entered <= CNT_W'(3));

endmodule

bind seqlock_top seqlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .key_vld      (key_vld),
  .key_a        (key_a),
  .key_b        (key_b),
  .unlock       (unlock),
  .keys_entered (keys_entered)
);

// File: tb/sim_seqlock_top.sv
`timescale 1ns/100ps
module sim_seqlock_top;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             key_vld = 1'b0;
  logic             key_a = 1'b0;
  logic             key_b = 1'b0;
  logic             unlock;
  logic [CNT_W-1:0] keys_entered;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model: keys taken so far and whether the entry is still correct
  int n_model = 0;
  bit good    = 1'b1;
  logic [CNT_W:0] prev_exp = '0;

  logic [CNT_W:0] exp_q[$];
  string          tag_q[$];

  always #2.5 clk = ~clk;

  seqlock_top #(.CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .key_vld      (key_vld),
    .key_a        (key_a),
    .key_b        (key_b),
    .unlock       (unlock),
    .keys_entered (keys_entered)
  );

  task automatic check(input string tag, input logic [CNT_W:0] act, input logic [CNT_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: unlock/count actual %b/%0d expected %b/%0d",
               tag, act[CNT_W], act[CNT_W-1:0], exp[CNT_W], exp[CNT_W-1:0]);
    end
  endtask

  // Driver: apply one cycle of input and queue the expected result
  task automatic press(input logic k, input logic a, input logic b, input string tag);
    bit is_a, is_b;
    @(negedge clk);
    key_vld = k; key_a = a; key_b = b;
    #1;
    check({tag, " R9 no same-cycle response"}, {unlock, keys_entered}, prev_exp);
    is_a = k && a && !b;
    is_b = k && !a && b;
    if (n_model == 3) begin
      n_model = 0;
    end else if (is_a || is_b) begin
      if (n_model == 0)      good = is_b;
      else if (n_model == 1) good = good && is_a;
      if (n_model == 2) n_model = (good && is_b) ? 3 : 0;
      else              n_model = n_model + 1;
    end
    prev_exp = {(n_model == 3), CNT_W'(n_model)};
    exp_q.push_back(prev_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle_cycle(input string tag);
    press(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; key_vld = 1'b0; key_a = 1'b0; key_b = 1'b0;
    @(posedge clk);
    #1;
    check({tag, " R1 reset"}, {unlock, keys_entered}, '0);
    @(negedge clk);
    rst = 1'b0;
    n_model = 0; good = 1'b1; prev_exp = '0;
  endtask

  // Monitor: compare each queued result just after its edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [CNT_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {unlock, keys_entered}, e);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset("R1 initial");

    idle_cycle("R5 idle hold");
    idle_cycle("R5 idle hold");

    // Correct entry with gaps
    press(1, 0, 1, "R3 first B");
    idle_cycle("R5 hold at 1");
    press(1, 1, 0, "R3 second A");
    idle_cycle("R5 hold at 2");
    press(1, 0, 1, "R3 third B unlock");
    press(1, 0, 1, "R4 key ignored while open");
    idle_cycle("R4 idle after open");

    // Illegal codes count as no key
    press(1, 1, 1, "R2 code 111 ignored");
    press(1, 0, 0, "R2 code 100 ignored");
    press(0, 1, 1, "R2 code 011 ignored");
    press(0, 0, 1, "R2 code 001 ignored");
    press(1, 0, 1, "R2 B after illegal");
    press(1, 1, 1, "R2 code 111 at count 1");
    press(0, 1, 0, "R2 code 010 at count 1");
    press(1, 1, 0, "R2 A counted");
    press(1, 0, 1, "R2 B unlock");
    idle_cycle("R4 back idle");

    // Wrong first key
    press(1, 1, 0, "R6 wrong first A");
    idle_cycle("R6 hold on bad path");
    press(1, 0, 1, "R6 second key");
    press(1, 1, 0, "R6 third key to idle");
    idle_cycle("R6 stays idle");

    // Wrong second key
    press(1, 0, 1, "R7 first B");
    press(1, 0, 1, "R7 wrong second B");
    idle_cycle("R7 hold at 2");
    press(1, 0, 1, "R7 third key to idle");

    // Wrong third key
    press(1, 0, 1, "R8 first B");
    press(1, 1, 0, "R8 second A");
    press(1, 1, 0, "R8 wrong third A");
    idle_cycle("R8 stays idle");

    // Held key
    press(1, 0, 1, "R10 held B cycle 1");
    press(1, 0, 1, "R10 held B cycle 2");
    press(1, 0, 1, "R10 held B cycle 3");
    idle_cycle("R10 idle after held");
    press(1, 0, 1, "R10 B");
    press(1, 1, 0, "R10 held A cycle 1");
    press(1, 1, 0, "R10 held A cycle 2");
    idle_cycle("R10 idle");

    // Reset in mid attempt
    press(1, 0, 1, "R1 pre-reset B");
    press(1, 1, 0, "R1 pre-reset A");
    idle_cycle("R11 count at 2");
    @(posedge clk);
    #2;
    do_reset("R1 mid attempt");
    idle_cycle("R1 idle after reset");
    press(1, 0, 1, "R3 B after reset");
    press(1, 1, 0, "R3 A after reset");
    press(1, 0, 1, "R3 B unlock after reset");
    idle_cycle("R4 idle after second open");

    @(negedge clk);
    key_vld = 1'b0; key_a = 1'b0; key_b = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule